// File: doc/BRIEF.md
# Lane-Masked SIMD Multiply-Add Core

This block is an eight-lane execution core that runs one scalar instruction stream. Each cycle it decodes one instruction and hands the same operation and register indices to every lane. Each lane has its own register file and a multiply-add unit. Software writes plain scalar code and the hardware spreads it across the lanes, so no vector instruction form exists.

Data-dependent branches are handled with a per-lane active mask. A compare instruction sets one predicate bit per lane. An IF narrows the mask to the lanes whose predicate is set and saves the enclosing mask on a small divergence stack. An ELSE switches to the complementary lanes of that parent, and an ENDIF brings the parent mask back. Every lane steps through both arms of the branch, but only active lanes commit results. When an arm has no active lane at all, the core drops the incoming instructions until the matching ELSE or ENDIF arrives. This acts as a jump past the empty arm.

A host port loads and reads individual lane registers. Two counters track efficiency: one counts issued lane-slots and the other counts lane operations that did useful work. The bench uses them to measure how much a divergent branch costs.

Top module: `simd_mask_core`

## Requirements
- R1: After reset, every lane register reads 0, `act_mask` is all ones, `skipping` is 0, and both counters are 0.
- R2: Opcode 1 (MAD) writes `rd = ra*rb + rc` in each active lane, modulo 2^DW, where `*` and `+` are integer multiply and add. The result is visible on the host read port in the cycle after issue.
- R3: Opcode 2 (LDI) writes the immediate into `rd` of each active lane.
- R4: Opcode 3 (CGT) sets an active lane's predicate to 1 when the signed value of `ra` is greater than zero, and to 0 otherwise. Inactive lanes keep their predicate.
- R5: Opcode 4 (IF) saves the current mask and sets the new mask to (current mask AND predicate).
- R6: Opcode 5 (ELSE) sets the mask to (saved parent mask AND NOT the lanes that took the IF).
- R7: Opcode 6 (ENDIF) restores the saved parent mask. IF blocks nest to a depth of DEPTH (4).
- R8: A lane outside the mask never changes its registers, including when its MAD result would overflow.
- R9: When IF or ELSE leaves the mask empty, `skipping` goes to 1. Instructions are then dropped until the matching ELSE or ENDIF at the same nesting level, with inner IF/ENDIF pairs counted. `skipping` is 1 exactly when the mask is empty.
- R10: Each MAD, LDI or CGT that issues adds LANES to `slot_cnt` and the number of active lanes to `useful_cnt`. Control ops, opcodes 0 and 7 (no operation), and dropped instructions add nothing.
- R11: `host_we` writes `host_wdata` into register `host_reg` of lane `host_lane`. If an instruction writes the same register in the same cycle, the instruction wins. `host_rdata` shows register `host_rreg` of lane `host_rlane` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_op | input | 3 | Opcode |
| in_rd | input | RW | Destination register index |
| in_ra | input | RW | Source A / compare register index |
| in_rb | input | RW | Source B register index |
| in_rc | input | RW | Addend register index |
| in_imm | input | DW | Immediate for LDI |
| host_we | input | 1 | Host lane-register write strobe |
| host_lane | input | LW | Lane for host write |
| host_reg | input | RW | Register for host write |
| host_wdata | input | DW | Host write data |
| host_rlane | input | LW | Lane for host read |
| host_rreg | input | RW | Register for host read |
| host_rdata | output | DW | Host read data |
| act_mask | output | LANES | Current active lane mask |
| skipping | output | 1 | Dropping instructions of an empty arm |
| useful_cnt | output | CW | Useful lane operations |
| slot_cnt | output | CW | Issued lane-slots |

## Verification
The bench builds the core with LANES=8, DW=16, NREG=8 and DEPTH=4. The 16-bit width lets a single 0x7FFF squared multiply-add wrap, so the overflow case for masked lanes can be reached. Eight lanes allow a one-hot predicate per lane, which drives the counters to exactly one useful operation in eight. A depth of four lets a chain of nested IFs reach the full divergence stack while the random phase stays inside it.

// File: rtl/simd_pkg.sv
package simd_pkg;
    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_MAD   = 3'd1,
        OP_LDI   = 3'd2,
        OP_CGT   = 3'd3,
        OP_IF    = 3'd4,
        OP_ELSE  = 3'd5,
        OP_ENDIF = 3'd6,
        OP_RSV   = 3'd7
    } op_e;
endpackage

// File: rtl/simd_lane.sv
module simd_lane #(
    parameter int DW   = 16,
    parameter int NREG = 8,
    parameter int RW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          exec_we,
    input  logic          sel_mad,
    input  logic [RW-1:0] rd,
    input  logic [RW-1:0] ra,
    input  logic [RW-1:0] rb,
    input  logic [RW-1:0] rc,
    input  logic [DW-1:0] imm,
    input  logic          host_we,
    input  logic [RW-1:0] host_reg,
    input  logic [DW-1:0] host_wdata,
    input  logic [RW-1:0] rreg,
    output logic [DW-1:0] rdata,
    output logic          gt
);
    logic [DW-1:0] regs_d [NREG];
    logic [DW-1:0] regs_q [NREG];
    logic [DW-1:0] prod_w;
    logic [DW-1:0] res_w;

    // Product and sum wrap at DW bits.
    assign prod_w = regs_q[ra] * regs_q[rb];
    assign res_w  = sel_mad ? (prod_w + regs_q[rc]) : imm;
    assign gt     = $signed(regs_q[ra]) > 0;
    assign rdata  = regs_q[rreg];

    always_comb begin
        regs_d = regs_q;
        if (host_we) regs_d[host_reg] = host_wdata;
        if (exec_we) regs_d[rd] = res_w;   // instruction write wins
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end
endmodule

// File: rtl/simd_mask_ctl.sv
module simd_mask_ctl
    import simd_pkg::*;
#(
    parameter int LANES = 8,
    parameter int DEPTH = 4,
    parameter int SKW   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  op_e              in_op,
    input  logic [LANES-1:0] lane_gt,
    output logic [LANES-1:0] act_mask,
    output logic             skipping,
    output logic             issue
);
    localparam int DPW = $clog2(DEPTH + 1);
    localparam int AW  = $clog2(DEPTH);

    typedef struct packed {
        logic [LANES-1:0] mask;
        logic [LANES-1:0] pred;
        logic [DPW-1:0]   dep;
        logic             skip;
        logic [SKW-1:0]   sdep;
    } ctl_t;

    ctl_t             s_d, s_q;
    logic [LANES-1:0] par_d [DEPTH];
    logic [LANES-1:0] par_q [DEPTH];
    logic [LANES-1:0] tak_d [DEPTH];
    logic [LANES-1:0] tak_q [DEPTH];
    logic             live;
    logic [AW-1:0]    top_i;
    logic [AW-1:0]    push_i;
    logic [LANES-1:0] nmask;

    always_comb begin
        s_d    = s_q;
        par_d  = par_q;
        tak_d  = tak_q;
        nmask  = '0;
        top_i  = AW'(s_q.dep - 1'b1);
        push_i = AW'(s_q.dep);
        live   = in_valid && (!s_q.skip ||
                 ((in_op == OP_ELSE || in_op == OP_ENDIF) && s_q.sdep == '0));
        issue  = live && (in_op == OP_MAD || in_op == OP_LDI || in_op == OP_CGT);

        if (in_valid && !live) begin
            // Dropping an empty arm: track nesting of inner blocks.
            if (in_op == OP_IF) s_d.sdep = s_q.sdep + 1'b1;
            else if (in_op == OP_ENDIF) s_d.sdep = s_q.sdep - 1'b1;
        end else if (live) begin
            unique case (in_op)
                OP_CGT: s_d.pred = (s_q.pred & ~s_q.mask) | (lane_gt & s_q.mask);
                OP_IF: begin
                    if (s_q.dep != DPW'(DEPTH)) begin
                        nmask          = s_q.mask & s_q.pred;
                        par_d[push_i]  = s_q.mask;
                        tak_d[push_i]  = nmask;
                        s_d.dep        = s_q.dep + 1'b1;
                        s_d.mask       = nmask;
                        s_d.skip       = (nmask == '0);
                        s_d.sdep       = '0;
                    end
                end
                OP_ELSE: begin
                    if (s_q.dep != '0) begin
                        nmask    = par_q[top_i] & ~tak_q[top_i];
                        s_d.mask = nmask;
                        s_d.skip = (nmask == '0);
                        s_d.sdep = '0;
                    end
                end
                OP_ENDIF: begin
                    if (s_q.dep != '0) begin
                        s_d.mask = par_q[top_i];
                        s_d.dep  = s_q.dep - 1'b1;
                        s_d.skip = 1'b0;
                        s_d.sdep = '0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mask <= '1;
            for (int i = 0; i < DEPTH; i++) begin
                par_q[i] <= '0;
                tak_q[i] <= '0;
            end
        end else begin
            s_q   <= s_d;
            par_q <= par_d;
            tak_q <= tak_d;
        end
    end

    assign act_mask = s_q.mask;
    assign skipping = s_q.skip;
endmodule

// File: rtl/simd_mask_core.sv
module simd_mask_core
    import simd_pkg::*;
#(
    parameter int LANES = 8,
    parameter int DW    = 16,
    parameter int NREG  = 8,
    parameter int DEPTH = 4,
    parameter int CW    = 32,
    parameter int RW    = $clog2(NREG),
    parameter int LW    = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       in_op,
    input  logic [RW-1:0]    in_rd,
    input  logic [RW-1:0]    in_ra,
    input  logic [RW-1:0]    in_rb,
    input  logic [RW-1:0]    in_rc,
    input  logic [DW-1:0]    in_imm,
    input  logic             host_we,
    input  logic [LW-1:0]    host_lane,
    input  logic [RW-1:0]    host_reg,
    input  logic [DW-1:0]    host_wdata,
    input  logic [LW-1:0]    host_rlane,
    input  logic [RW-1:0]    host_rreg,
    output logic [DW-1:0]    host_rdata,
    output logic [LANES-1:0] act_mask,
    output logic             skipping,
    output logic [CW-1:0]    useful_cnt,
    output logic [CW-1:0]    slot_cnt
);
    localparam int SKW = $clog2(DEPTH + 1) + 1;

    typedef struct packed {
        logic [CW-1:0] useful;
        logic [CW-1:0] slot;
    } cnt_t;

    op_e              op_w;
    logic             issue;
    logic             wr_op;
    logic [LANES-1:0] lane_gt;
    logic [DW-1:0]    lane_rd [LANES];
    logic [CW-1:0]    act_cnt;
    cnt_t             cnt_d, cnt_q;

    assign op_w  = op_e'(in_op);
    assign wr_op = (op_w == OP_MAD) || (op_w == OP_LDI);

    simd_mask_ctl #(.LANES(LANES), .DEPTH(DEPTH), .SKW(SKW)) ctl_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(op_w),
        .lane_gt(lane_gt), .act_mask(act_mask), .skipping(skipping), .issue(issue)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        simd_lane #(.DW(DW), .NREG(NREG), .RW(RW)) lane_i (
            .clk(clk), .rst_n(rst_n),
            .exec_we(issue && wr_op && act_mask[l]),
            .sel_mad(op_w == OP_MAD),
            .rd(in_rd), .ra(in_ra), .rb(in_rb), .rc(in_rc), .imm(in_imm),
            .host_we(host_we && (host_lane == LW'(l))),
            .host_reg(host_reg), .host_wdata(host_wdata),
            .rreg(host_rreg), .rdata(lane_rd[l]), .gt(lane_gt[l])
        );
    end

    assign host_rdata = lane_rd[host_rlane];

    always_comb begin
        act_cnt = '0;
        for (int i = 0; i < LANES; i++) act_cnt = act_cnt + CW'(act_mask[i]);
        cnt_d = cnt_q;
        if (issue) begin
            cnt_d.useful = cnt_q.useful + act_cnt;
            cnt_d.slot   = cnt_q.slot + CW'(LANES);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign useful_cnt = cnt_q.useful;
    assign slot_cnt   = cnt_q.slot;
endmodule

// File: rtl/simd_core_chk.sv
module simd_core_chk #(
    parameter int LANES = 8,
    parameter int CW    = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [2:0]       in_op,
    input logic [LANES-1:0] act_mask,
    input logic             skipping,
    input logic [CW-1:0]    useful_cnt,
    input logic [CW-1:0]    slot_cnt
);
    logic comp_go;
    logic if_go;
    assign comp_go = in_valid && !skipping &&
                     (in_op == 3'd1 || in_op == 3'd2 || in_op == 3'd3);
    assign if_go   = in_valid && !skipping && in_op == 3'd4;

    AST_SKIP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        skipping |-> act_mask == '0);   // R9
    AST_RUN_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !skipping |-> act_mask != '0);  // R9
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        comp_go |=> slot_cnt == $past(slot_cnt) + CW'(LANES));   // R10
    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !comp_go |=> $stable(slot_cnt) && $stable(useful_cnt));   // R10
    AST_USEFUL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        comp_go |=> useful_cnt == $past(useful_cnt) + CW'($countones($past(act_mask))));   // R10
    AST_IF_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        if_go |=> (act_mask & ~$past(act_mask)) == '0);   // R5
endmodule

bind simd_mask_core simd_core_chk #(.LANES(LANES), .CW(CW)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .act_mask(act_mask), .skipping(skipping),
    .useful_cnt(useful_cnt), .slot_cnt(slot_cnt)
);

// File: tb/simd_mask_core_tb.sv
`timescale 1ns/1ps
module simd_mask_core_tb_top;
    localparam int LANES = 8, DW = 16, NREG = 8, DEPTH = 4, CW = 32;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 0;
    logic [2:0] in_op = 0, in_rd = 0, in_ra = 0, in_rb = 0, in_rc = 0;
    logic [DW-1:0] in_imm = 0;
    logic host_we = 0;
    logic [2:0] host_lane = 0, host_reg = 0, host_rlane = 0, host_rreg = 0;
    logic [DW-1:0] host_wdata = 0, host_rdata;
    logic [LANES-1:0] act_mask;
    logic skipping;
    logic [CW-1:0] useful_cnt, slot_cnt;

    always #10 clk = ~clk;

    simd_mask_core #(.LANES(LANES), .DW(DW), .NREG(NREG), .DEPTH(DEPTH), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_rd(in_rd), .in_ra(in_ra), .in_rb(in_rb), .in_rc(in_rc), .in_imm(in_imm),
        .host_we(host_we), .host_lane(host_lane), .host_reg(host_reg),
        .host_wdata(host_wdata), .host_rlane(host_rlane), .host_rreg(host_rreg),
        .host_rdata(host_rdata), .act_mask(act_mask), .skipping(skipping),
        .useful_cnt(useful_cnt), .slot_cnt(slot_cnt)
    );

    int n_run = 0, n_fail = 0;
    bit done = 0;

    // Bench model of the requirements
    logic [DW-1:0] m_reg [LANES][NREG];
    logic [LANES-1:0] m_mask, m_pred;
    logic [LANES-1:0] m_par [DEPTH];
    logic [LANES-1:0] m_tak [DEPTH];
    int m_dep, m_sdep, open_cnt;
    bit m_skip;
    logic [CW-1:0] m_use, m_slot;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int l = 0; l < LANES; l++) for (int r = 0; r < NREG; r++) m_reg[l][r] = '0;
        m_mask = '1; m_pred = '0; m_dep = 0; m_sdep = 0; m_skip = 0;
        m_use = '0; m_slot = '0; open_cnt = 0;
    endtask

    task automatic model_exec(input int op, input int rd, input int ra, input int rb,
                              input int rc, input logic [DW-1:0] imm);
        logic [LANES-1:0] nm;
        bit live = !m_skip || ((op == 5 || op == 6) && m_sdep == 0);
        if (!live) begin
            if (op == 4) m_sdep++;
            else if (op == 6) m_sdep--;
            return;
        end
        if (op == 1 || op == 2 || op == 3) begin
            logic [DW-1:0] nv [LANES];
            for (int l = 0; l < LANES; l++) begin
                logic [2*DW-1:0] p = m_reg[l][ra] * m_reg[l][rb];
                nv[l] = (op == 1) ? DW'(p[DW-1:0] + m_reg[l][rc]) : imm;
            end
            for (int l = 0; l < LANES; l++) if (m_mask[l]) begin
                if (op == 3) m_pred[l] = $signed(m_reg[l][ra]) > 0;
                else m_reg[l][rd] = nv[l];
            end
            m_slot += LANES;
            m_use += $countones(m_mask);
        end else if (op == 4) begin
            if (m_dep < DEPTH) begin
                nm = m_mask & m_pred;
                m_par[m_dep] = m_mask; m_tak[m_dep] = nm; m_dep++;
                m_mask = nm; m_skip = (nm == 0); m_sdep = 0;
            end
        end else if (op == 5) begin
            if (m_dep > 0) begin
                nm = m_par[m_dep-1] & ~m_tak[m_dep-1];
                m_mask = nm; m_skip = (nm == 0); m_sdep = 0;
            end
        end else if (op == 6) begin
            if (m_dep > 0) begin
                m_mask = m_par[m_dep-1]; m_dep--; m_skip = 0; m_sdep = 0;
            end
        end
    endtask

    task automatic exec(input int op, input int rd, input int ra, input int rb,
                        input int rc, input logic [DW-1:0] imm);
        @(negedge clk);
        in_valid = 1; in_op = op[2:0]; in_rd = rd[2:0]; in_ra = ra[2:0];
        in_rb = rb[2:0]; in_rc = rc[2:0]; in_imm = imm;
        @(posedge clk); #1;
        in_valid = 0;
        model_exec(op, rd, ra, rb, rc, imm);
        if (op == 4) open_cnt++;
        if (op == 6 && open_cnt > 0) open_cnt--;
    endtask

    task automatic hwrite(input int l, input int r, input logic [DW-1:0] v);
        @(negedge clk);
        host_we = 1; host_lane = l[2:0]; host_reg = r[2:0]; host_wdata = v;
        @(posedge clk); #1;
        host_we = 0;
        m_reg[l][r] = v;
    endtask

    task automatic rdreg(input int l, input int r, output logic [DW-1:0] v);
        host_rlane = l[2:0]; host_rreg = r[2:0]; #1; v = host_rdata;
    endtask

    task automatic chk_state(input string req);
        check(act_mask === m_mask, {req, " act_mask"}, 64'(act_mask), 64'(m_mask));
        check(skipping === m_skip, {req, " skipping"}, 64'(skipping), 64'(m_skip));
        check(useful_cnt === m_use && slot_cnt === m_slot, {req, " counters"},
              {useful_cnt, slot_cnt}, {m_use, m_slot});
    endtask

    task automatic chk_regs(input string req);
        bit ok = 1; logic [DW-1:0] v, ev; ev = '0; v = '0;
        for (int l = 0; l < LANES; l++) for (int r = 0; r < NREG; r++) begin
            logic [DW-1:0] t;
            rdreg(l, r, t);
            if (t !== m_reg[l][r] && ok) begin ok = 0; v = t; ev = m_reg[l][r]; end
        end
        check(ok, {req, " lane registers"}, 64'(v), 64'(ev));
    endtask

    task automatic expect_reg(input int l, input int r, input logic [DW-1:0] e, input string req);
        logic [DW-1:0] v;
        rdreg(l, r, v);
        check(v === e, req, 64'(v), 64'(e));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [CW-1:0] u0, s0;
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(act_mask === 8'hFF && skipping === 0, "R1 mask/skip", 64'({act_mask, skipping}), 64'h1FE);
        check(useful_cnt === 0 && slot_cnt === 0, "R1 counters", {useful_cnt, slot_cnt}, 64'h0);
        chk_regs("R1");

        // R2 R3 multiply-add with negative operand
        exec(2, 1, 0, 0, 0, 16'd5);
        exec(2, 2, 0, 0, 0, 16'hFFFD);
        exec(2, 3, 0, 0, 0, 16'd7);
        exec(1, 4, 1, 2, 3, 0);
        expect_reg(0, 4, 16'hFFF8, "R2 mad 5*-3+7");
        expect_reg(7, 1, 16'd5, "R3 ldi");

        // R4 R5 R6 R7 two-way divergence
        for (int l = 0; l < LANES; l++) hwrite(l, 0, DW'(l - 3));
        exec(3, 0, 0, 0, 0, 0);
        exec(4, 0, 0, 0, 0, 0);
        check(act_mask === 8'hF0, "R5 if mask", 64'(act_mask), 64'hF0);
        exec(1, 5, 0, 0, 0, 0);
        exec(5, 0, 0, 0, 0, 0);
        check(act_mask === 8'h0F, "R6 else mask", 64'(act_mask), 64'h0F);
        exec(2, 5, 0, 0, 0, 16'h0);
        exec(6, 0, 0, 0, 0, 0);
        check(act_mask === 8'hFF, "R7 endif mask", 64'(act_mask), 64'hFF);
        expect_reg(5, 5, 16'd6, "R4 taken lane result");
        expect_reg(1, 5, 16'd0, "R6 else lane result");

        // R8 masked lanes keep registers under overflow
        exec(2, 6, 0, 0, 0, 16'h7FFF);
        exec(2, 7, 0, 0, 0, 16'h1234);
        for (int l = 0; l < LANES; l++) hwrite(l, 0, (l == 0) ? 16'd1 : 16'd0);
        exec(3, 0, 0, 0, 0, 0);
        exec(4, 0, 0, 0, 0, 0);
        exec(1, 7, 6, 6, 6, 0);
        exec(6, 0, 0, 0, 0, 0);
        expect_reg(0, 7, 16'h8000, "R8 active lane wraps");
        expect_reg(3, 7, 16'h1234, "R8 masked lane unchanged");
        chk_regs("R8");

        // R10 one-hot divergence: 1/8 of peak inside each arm
        for (int k = 0; k < LANES; k++) begin
            for (int l = 0; l < LANES; l++) hwrite(l, 0, (l == k) ? 16'd1 : 16'd0);
            exec(3, 0, 0, 0, 0, 0);
            exec(4, 0, 0, 0, 0, 0);
            u0 = useful_cnt; s0 = slot_cnt;
            for (int j = 0; j < 4; j++) exec(1, 2, 2, 3, 1, 0);
            check(useful_cnt - u0 == 4 && slot_cnt - s0 == 32, "R10 one-hot efficiency",
                  {useful_cnt - u0, slot_cnt - s0}, {32'd4, 32'd32});
            exec(6, 0, 0, 0, 0, 0);
        end
        chk_state("R10");

        // R9 empty arm is dropped, nested blocks counted
        for (int l = 0; l < LANES; l++) hwrite(l, 0, 16'd0);
        exec(3, 0, 0, 0, 0, 0);
        exec(4, 0, 0, 0, 0, 0);
        check(skipping === 1 && act_mask === 0, "R9 enter skip", 64'({skipping, act_mask}), 64'h100);
        u0 = useful_cnt; s0 = slot_cnt;
        exec(2, 1, 0, 0, 0, 16'hDEAD);
        exec(4, 0, 0, 0, 0, 0);
        exec(5, 0, 0, 0, 0, 0);
        exec(1, 1, 1, 1, 1, 0);
        exec(6, 0, 0, 0, 0, 0);
        check(skipping === 1 && slot_cnt == s0 && useful_cnt == u0, "R9 still skipping",
              64'({skipping, slot_cnt}), 64'({1'b1, s0}));
        exec(5, 0, 0, 0, 0, 0);
        check(skipping === 0 && act_mask === 8'hFF, "R9 else resumes", 64'({skipping, act_mask}), 64'hFF);
        exec(2, 1, 0, 0, 0, 16'h55);
        exec(6, 0, 0, 0, 0, 0);
        expect_reg(4, 1, 16'h55, "R9 resumed ldi");
        chk_regs("R9");
        chk_state("R9");

        // R7 nesting to depth 4
        for (int l = 0; l < LANES; l++) for (int r = 0; r < 4; r++) hwrite(l, r, DW'(l - 2*r));
        for (int r = 0; r < 4; r++) begin exec(3, 0, r, 0, 0, 0); exec(4, 0, 0, 0, 0, 0); end
        check(act_mask === 8'h80, "R7 depth4 mask", 64'(act_mask), 64'h80);
        exec(6, 0, 0, 0, 0, 0);
        check(act_mask === 8'hE0, "R7 pop to 3", 64'(act_mask), 64'hE0);
        exec(6, 0, 0, 0, 0, 0);
        check(act_mask === 8'hF8, "R7 pop to 2", 64'(act_mask), 64'hF8);
        exec(6, 0, 0, 0, 0, 0);
        exec(6, 0, 0, 0, 0, 0);
        check(act_mask === 8'hFF, "R7 pop to 0", 64'(act_mask), 64'hFF);

        // R11 same-cycle host and instruction write: instruction wins
        @(negedge clk);
        host_we = 1; host_lane = 3'd2; host_reg = 3'd1; host_wdata = 16'hAAAA;
        in_valid = 1; in_op = 3'd2; in_rd = 3'd1; in_imm = 16'h0BBB;
        @(posedge clk); #1;
        host_we = 0; in_valid = 0;
        m_reg[2][1] = 16'hAAAA;
        model_exec(2, 1, 0, 0, 0, 16'h0BBB);
        expect_reg(2, 1, 16'h0BBB, "R11 instruction wins");
        hwrite(6, 3, 16'h4321);
        expect_reg(6, 3, 16'h4321, "R11 host write");

        // Random phase: R2 R3 R4 R5 R6 R8 R9 R10 against model
        void'($urandom(32'd2024));
        for (int n = 0; n < 400; n++) begin
            int r = $urandom_range(0, 99);
            int op;
            if (r < 8) begin
                hwrite($urandom_range(0, 7), $urandom_range(0, 7),
                       DW'($signed($urandom_range(0, 8)) - 4));
                continue;
            end
            if (r < 40) op = 1;
            else if (r < 52) op = 2;
            else if (r < 66) op = 3;
            else if (r < 76) op = (open_cnt < DEPTH) ? 4 : 1;
            else if (r < 84) op = (open_cnt > 0) ? 5 : 2;
            else if (r < 94) op = (open_cnt > 0) ? 6 : 3;
            else op = (r[0]) ? 7 : 0;
            exec(op, $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7),
                 $urandom_range(0, 7),
                 (r[1]) ? DW'($urandom) : DW'($signed($urandom_range(0, 6)) - 3));
            chk_state("R10 random");
            if (n % 25 == 0) chk_regs("R8 random");
        end
        while (open_cnt > 0) exec(6, 0, 0, 0, 0, 0);
        chk_state("R7 random close");
        chk_regs("R2 random final");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule